// File: doc/BRIEF.md
# ALU Condition-Flag Update Unit

This execution unit computes add, subtract, increment, decrement, variable-count left shift, flag-free address add and conditional-branch evaluation on `DATA_W`-bit operands. It holds four condition flags. The carry bit sits in its own register, and zero, sign and overflow share a second register. A per-opcode write mask decides which of these two registers, and which result register, take new values on a given operation. Bits that are not written keep their earlier values.

Branch operations only read the stored flags. They register a taken bit and a target of `a + b`, and they leave the flags and the result alone. The surrounding core supplies a decoded opcode, two operands, a shift count and a valid strobe. It receives the registered result, the flags and the branch outcome one clock later.

Top module: `alu_flag_unit`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the result, target, taken bit and all four flags go to zero.
- R2: Add (op 0) and subtract (op 1) write the result and all four flags. Carry is the unsigned carry-out for add and the borrow (`a < b` unsigned) for subtract. Zero means the result is all zeros, and sign is the result MSB. `flags_o` packs bit0 carry, bit1 zero, bit2 sign and bit3 overflow.
- R3: For add, overflow is set when the operand signs agree and the result sign differs from them. For subtract, the same test is applied with the sign of `b` inverted.
- R4: Increment (op 2, `a+1`) and decrement (op 3, `a-1`) write the result, zero, sign and overflow, and keep carry. Overflow is set when the operation wraps across the signed limit.
- R5: Shift-left (op 4) uses only the low log2(`DATA_W`) bits of `cnt_i`. When that masked count is zero, the result becomes `a` and all four flags keep their values.
- R6: A shift with a nonzero masked count k writes `a << k` and sets carry to the last bit shifted out, which is `a[DATA_W-k]`. It sets zero and sign from the result and clears overflow.
- R7: Address add (op 5) writes `a + b` to the result and changes no flag.
- R8: Branch ops 8 (carry clear), 9 (carry set), 10 (zero set) and 11 (zero clear) evaluate their condition on the flags held before the edge. They register `taken_o` and `target_o = a + b`, and they leave the result and the flags unchanged.
- R9: A valid non-branch operation clears `taken_o` and leaves `target_o` unchanged. Opcodes 6, 7 and 12 to 15 change nothing except clearing `taken_o`.
- R10: While `valid_i` is low, every output register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | DATA_W | First operand / branch base |
| b_i | input | DATA_W | Second operand / branch offset |
| cnt_i | input | CNT_W | Shift count (masked) |
| result_o | output | DATA_W | Registered result |
| flags_o | output | 4 | {overflow, sign, zero, carry} |
| taken_o | output | 1 | Registered branch decision |
| target_o | output | DATA_W | Registered branch target |

## Verification
The bench builds the unit with `DATA_W = 16` and `CNT_W = 8`. With a 16-bit word, carry-out, borrow and signed wrap are all reached with short operands such as 0xFFFF, 0x7FFF and 0x8000. An 8-bit count gives values of 16, 32 and 48, whose low four bits are zero, so the bench can check that such shifts are treated as shifts by zero. A shift by 15 reaches the case where the last bit shifted out is bit 1.

// File: rtl/alu_flag_pkg.sv
// Shared opcode encoding and flag layout for the condition-flag unit.
// Assumes a 4-bit decoded opcode supplied by the core's decoder.
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_SHL = 4'd4,
        OP_LEA = 4'd5,
        OP_BCC = 4'd8,   // taken when carry clear
        OP_BCS = 4'd9,   // taken when carry set
        OP_BZS = 4'd10,  // taken when zero set
        OP_BZC = 4'd11   // taken when zero clear
    } alu_op_e;

    // Flags other than carry, kept in one register
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
    } zso_t;

    // Per-operation write enables
    typedef struct packed {
        logic res_we;
        logic cy_we;
        logic zso_we;
        logic br;
    } wr_mask_t;

    function automatic logic is_branch(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/afu_datapath.sv
// Arithmetic datapath: computes the candidate result and candidate flags for
// every non-branch operation. Purely combinational; the write mask decides
// what is stored. Assumes DATA_W is a power of two.
module afu_datapath
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output zso_t              zso_o,
    output logic              shamt_zero_o
);
    localparam logic [CNT_W-1:0]  CNT_MASK = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
    localparam int                MSB      = DATA_W - 1;

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W:0]   dif_ext;
    logic [DATA_W:0]   shl_ext;
    logic [CNT_W-1:0]  amt;
    logic              ovf_c;

    // Wide intermediates that keep the carry / borrow / last shifted-out bit
    always_comb begin
        sum_ext = {1'b0, a_i} + {1'b0, b_i};
        dif_ext = {1'b0, a_i} - {1'b0, b_i};
        amt     = cnt_i & CNT_MASK;
        shl_ext = {1'b0, a_i} << amt;
    end

    assign shamt_zero_o = (amt == '0);

    // Select result, carry and overflow per operation
    always_comb begin
        res_o = a_i;
        cy_o  = 1'b0;
        ovf_c = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                res_o = sum_ext[DATA_W-1:0];
                cy_o  = sum_ext[DATA_W];
                ovf_c = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
            end
            OP_SUB: begin
                res_o = dif_ext[DATA_W-1:0];
                cy_o  = dif_ext[DATA_W];
                ovf_c = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
            end
            OP_INC: begin
                res_o = a_i + ONE;
                ovf_c = !a_i[MSB] && res_o[MSB];
            end
            OP_DEC: begin
                res_o = a_i - ONE;
                ovf_c = a_i[MSB] && !res_o[MSB];
            end
            OP_SHL: begin
                res_o = shl_ext[DATA_W-1:0];
                cy_o  = shamt_zero_o ? 1'b0 : shl_ext[DATA_W];
            end
            OP_LEA:  res_o = sum_ext[DATA_W-1:0];
            default: res_o = sum_ext[DATA_W-1:0]; // branch target path
        endcase
    end

    // Zero and sign follow the selected result
    always_comb begin
        zso_o.ovf = ovf_c;
        zso_o.sgn = res_o[MSB];
        zso_o.zro = (res_o == '0);
    end

endmodule

// File: rtl/afu_write_mask.sv
// Per-opcode write mask: decides which storage elements an operation updates.
// Carry and the zero/sign/overflow group have independent enables so an
// operation may write one group and preserve the other.
module afu_write_mask
    import alu_flag_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic       shamt_zero_i,
    output wr_mask_t   mask_o
);
    // Decode the opcode into enables
    always_comb begin
        mask_o = '0;
        unique case (op_i)
            OP_ADD, OP_SUB: mask_o = '{res_we: 1'b1, cy_we: 1'b1, zso_we: 1'b1, br: 1'b0};
            OP_INC, OP_DEC: mask_o = '{res_we: 1'b1, cy_we: 1'b0, zso_we: 1'b1, br: 1'b0};
            OP_SHL: mask_o = '{res_we: 1'b1, cy_we: !shamt_zero_i,
                               zso_we: !shamt_zero_i, br: 1'b0};
            OP_LEA: mask_o = '{res_we: 1'b1, cy_we: 1'b0, zso_we: 1'b0, br: 1'b0};
            OP_BCC, OP_BCS, OP_BZS, OP_BZC:
                    mask_o = '{res_we: 1'b0, cy_we: 1'b0, zso_we: 1'b0, br: 1'b1};
            default: mask_o = '0;
        endcase
    end

endmodule

// File: rtl/afu_branch_cond.sv
// Branch condition evaluator: reads the stored carry and zero flags only.
// Assumes op_i[1:0] selects the condition within the branch opcode group.
module afu_branch_cond (
    input  logic [3:0] op_i,
    input  logic       cy_i,
    input  logic       zro_i,
    output logic       take_o
);
    // Condition select by the low two opcode bits
    always_comb begin
        unique case (op_i[1:0])
            2'd0: take_o = !cy_i;
            2'd1: take_o = cy_i;
            2'd2: take_o = zro_i;
            default: take_o = !zro_i;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Top of the condition-flag update unit. Holds the result, carry, the
// zero/sign/overflow group and the branch outcome, each updated under the
// per-opcode write mask on a valid strobe. Synchronous active-low reset.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o,
    output logic              taken_o,
    output logic [DATA_W-1:0] target_o
);
    logic [DATA_W-1:0] dp_res;
    logic              dp_cy;
    zso_t              dp_zso;
    logic              shamt_zero;
    wr_mask_t          mask;
    logic              take_c;

    logic              cy_q;
    zso_t              zso_q;

    afu_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .op_i         (op_i),
        .a_i          (a_i),
        .b_i          (b_i),
        .cnt_i        (cnt_i),
        .res_o        (dp_res),
        .cy_o         (dp_cy),
        .zso_o        (dp_zso),
        .shamt_zero_o (shamt_zero)
    );

    afu_write_mask u_mask (
        .op_i         (op_i),
        .shamt_zero_i (shamt_zero),
        .mask_o       (mask)
    );

    afu_branch_cond u_br (
        .op_i   (op_i),
        .cy_i   (cy_q),
        .zro_i  (zso_q.zro),
        .take_o (take_c)
    );

    // Carry storage, separate from the other flags
    always_ff @(posedge clk) begin
        if (!rst_n)                   cy_q <= 1'b0;
        else if (valid_i && mask.cy_we) cy_q <= dp_cy;
    end

    // Zero / sign / overflow storage
    always_ff @(posedge clk) begin
        if (!rst_n)                    zso_q <= '0;
        else if (valid_i && mask.zso_we) zso_q <= dp_zso;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n)                    result_o <= '0;
        else if (valid_i && mask.res_we) result_o <= dp_res;
    end

    // Branch outcome: taken set by branches, cleared by any other valid op
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o  <= 1'b0;
            target_o <= '0;
        end else if (valid_i) begin
            taken_o <= mask.br && take_c;
            if (mask.br) target_o <= dp_res;
        end
    end

    assign flags_o = {zso_q.ovf, zso_q.sgn, zso_q.zro, cy_q};

    AST_BRANCH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && is_branch($past(op_i)))
            |-> ($stable(flags_o) && $stable(result_o))); // R8

    AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
            |-> $stable(flags_o[0])); // R4

    AST_SHIFT_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(op_i) == OP_SHL
         && $past(cnt_i[$clog2(DATA_W)-1:0]) == '0)
            |-> $stable(flags_o)); // R5

    AST_LEA_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(op_i) == OP_LEA)
            |-> $stable(flags_o)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i))
            |-> ($stable(flags_o) && $stable(result_o) && $stable(taken_o) && $stable(target_o))); // R10

    AST_TAKEN_ONLY_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(taken_o) |-> ($past(valid_i) && is_branch($past(op_i)))); // R9

endmodule

// File: tb/alu_flag_unit_tb_top.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each clock edge.
module alu_flag_unit_tb_top;
    localparam int W  = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic [W-1:0]  result_o;
    logic [3:0]    flags_o;
    logic          taken_o;
    logic [W-1:0]  target_o;

    typedef struct {
        logic [W-1:0] res;
        logic [3:0]   flg;
        logic         tk;
        logic [W-1:0] tgt;
        string        req;
    } exp_t;

    exp_t         sb_q[$];
    int           n_chk = 0;
    int           n_err = 0;
    logic [W-1:0] m_res = '0;
    logic [3:0]   m_flg = '0;
    logic         m_tk = 1'b0;
    logic [W-1:0] m_tgt = '0;

    alu_flag_unit #(.DATA_W(W), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .cnt_i(cnt_i), .result_o(result_o),
        .flags_o(flags_o), .taken_o(taken_o), .target_o(target_o)
    );

    always #5 clk = ~clk;

    // Reference model from the requirements; flags {O,S,Z,C}
    task automatic drive(input logic v, input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [CW-1:0] c, input string req);
        logic [W:0] wide;
        logic [W-1:0] r;
        int k;
        exp_t e;
        @(negedge clk);
        valid_i = v; op_i = op; a_i = a; b_i = b; cnt_i = c;
        if (v) begin
            r = m_res;
            case (op)
                4'd0: begin wide = {1'b0,a} + {1'b0,b}; r = wide[W-1:0];
                      m_flg = {(a[W-1]==b[W-1]) && (r[W-1]!=a[W-1]), r[W-1], r==0, wide[W]}; end
                4'd1: begin r = a - b;
                      m_flg = {(a[W-1]!=b[W-1]) && (r[W-1]!=a[W-1]), r[W-1], r==0, a<b}; end
                4'd2: begin r = a + 1; m_flg = {a==16'h7FFF, r[W-1], r==0, m_flg[0]}; end
                4'd3: begin r = a - 1; m_flg = {a==16'h8000, r[W-1], r==0, m_flg[0]}; end
                4'd4: begin k = int'(c) % W;
                      if (k == 0) r = a;
                      else begin r = a << k; m_flg = {1'b0, r[W-1], r==0, a[W-k]}; end end
                4'd5: r = a + b;
                default: ;
            endcase
            if (op <= 4'd5) m_res = r;
            if (op >= 4'd8 && op <= 4'd11) begin
                case (op)
                    4'd8:  m_tk = !m_flg[0];
                    4'd9:  m_tk = m_flg[0];
                    4'd10: m_tk = m_flg[1];
                    default: m_tk = !m_flg[1];
                endcase
                m_tgt = a + b;
            end else m_tk = 1'b0;
        end
        e.res = m_res; e.flg = m_flg; e.tk = m_tk; e.tgt = m_tgt; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (result_o !== e.res || flags_o !== e.flg || taken_o !== e.tk || target_o !== e.tgt) begin
                n_err++;
                $display("FAIL %s: got res=%h flg=%b tk=%b tgt=%h exp res=%h flg=%b tk=%b tgt=%h",
                         e.req, result_o, flags_o, taken_o, target_o, e.res, e.flg, e.tk, e.tgt);
            end
        end
    end

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        valid_i = 1'b1; op_i = 4'd0; a_i = 16'hFFFF; b_i = 16'h0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++; // R1 reset state
        if (result_o !== '0 || flags_o !== '0 || taken_o !== 1'b0 || target_o !== '0) begin
            n_err++;
            $display("FAIL R1: got res=%h flg=%b exp all zero", result_o, flags_o);
        end
        valid_i = 1'b0;
        rst_n = 1'b1;
        // R2 add with carry-out and zero
        drive(1, 4'd0, 16'hFFFF, 16'h0001, 0, "R2 add carry");
        // R3 add signed overflow
        drive(1, 4'd0, 16'h7FFF, 16'h0001, 0, "R3 add ovf");
        // R2 subtract with borrow
        drive(1, 4'd1, 16'h0003, 16'h0005, 0, "R2 sub borrow");
        // R3 subtract overflow
        drive(1, 4'd1, 16'h8000, 16'h0001, 0, "R3 sub ovf");
        // R4 increment keeps carry (carry currently 0, set it first)
        drive(1, 4'd0, 16'hFFFF, 16'h0002, 0, "R2 add set carry");
        drive(1, 4'd2, 16'h7FFF, 0, 0, "R4 inc ovf keeps carry");
        drive(1, 4'd3, 16'h0001, 0, 0, "R4 dec zero keeps carry");
        drive(1, 4'd3, 16'h8000, 0, 0, "R4 dec ovf");
        // R5 masked-zero shifts keep flags
        drive(1, 4'd4, 16'h1234, 0, 8'd16, "R5 shift count 16");
        drive(1, 4'd4, 16'h00F0, 0, 8'd0, "R5 shift count 0");
        drive(1, 4'd4, 16'hABCD, 0, 8'd48, "R5 shift count 48");
        // R6 nonzero shifts
        drive(1, 4'd4, 16'h8001, 0, 8'd1, "R6 shift 1 carry");
        drive(1, 4'd4, 16'h0002, 0, 8'd15, "R6 shift 15 carry");
        drive(1, 4'd4, 16'h0001, 0, 8'd17, "R6 shift masked 17");
        // R7 address add
        drive(1, 4'd1, 16'h0000, 16'h0001, 0, "R2 sub all ones");
        drive(1, 4'd5, 16'h1000, 16'h0234, 0, "R7 lea no flags");
        // R8 branches
        drive(1, 4'd9, 16'h0100, 16'h0010, 0, "R8 branch carry set");
        drive(1, 4'd8, 16'h0200, 16'h0020, 0, "R8 branch carry clear");
        drive(1, 4'd1, 16'h0005, 16'h0005, 0, "R2 sub zero");
        drive(1, 4'd10, 16'h0300, 16'h0030, 0, "R8 branch zero set");
        drive(1, 4'd11, 16'h0400, 16'h0040, 0, "R8 branch zero clear");
        // R9 non-branch clears taken, unused opcodes do nothing else
        drive(1, 4'd10, 16'h0500, 16'h0050, 0, "R8 branch taken again");
        drive(1, 4'd6, 16'hFFFF, 16'hFFFF, 0, "R9 unused op 6");
        drive(1, 4'd10, 16'h0600, 16'h0060, 0, "R8 branch retake");
        drive(1, 4'd14, 16'h1111, 16'h2222, 8'd3, "R9 unused op 14");
        // R10 idle holds
        drive(1, 4'd10, 16'h0700, 16'h0070, 0, "R8 branch before idle");
        drive(0, 4'd0, 16'hFFFF, 16'hFFFF, 0, "R10 idle add");
        drive(0, 4'd4, 16'h8000, 0, 8'd1, "R10 idle shift");
        drive(1, 4'd0, 16'h8000, 16'h8000, 0, "R3 add neg ovf");
        drive(0, 4'd0, 0, 0, 0, "R10 drain");
        @(negedge clk);
        valid_i = 1'b0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule